// File: doc/BRIEF.md
# Linked-Descriptor 2D DMA Engine

This block is a single DMA channel that walks a chain of control blocks held in memory. Once started with a block pointer, it reads six 32-bit words at that pointer (transfer info, source address, destination address, length, stride and next-block pointer). It then moves data one 32-bit word per beat from source to destination. When the block is done it raises an end flag, and optionally an interrupt, and moves on to the next-block pointer. The chain ends when that pointer is zero or when the channel enable is low at a block boundary. The engine then drops `active` and raises `paused`.

A two-dimensional mode packs a row count and a row length into the length word. In this mode, signed 16-bit per-row strides are added to the source and destination addresses between rows. Each side of the transfer can be set to increment its address by 4 per beat, to hold its address, or to be ignored. An ignored source supplies zero data and issues no read. An ignored destination issues no write. Memory is reached through one valid/ready request channel and one response channel, with at most one access in flight.

The controller is a single state machine with these states:
- `S_IDLE` goes to `S_CHECK` on `start`.
- `S_CHECK` goes to `S_FETCH_REQ` when the pointer is non-zero and the channel is enabled. Otherwise it goes back to `S_IDLE` and the stop takes effect.
- `S_FETCH_REQ` and `S_FETCH_WAIT` alternate once for each of the six descriptor words, then go to `S_SETUP`.
- `S_SETUP` loads the addresses and counters and goes to `S_ROW_CHK`.
- `S_ROW_CHK` goes to one of three places:
  - `S_RD_REQ` when words remain and the source is read.
  - `S_WR_REQ` when the source is ignored and the destination is written.
  - `S_BEAT_END` when both sides are ignored.
  - When the row is empty it goes to `S_ROW_END` instead.
- `S_RD_REQ` goes to `S_RD_WAIT`. `S_RD_WAIT` goes to `S_WR_REQ`, or to `S_BEAT_END` when the destination is ignored.
- `S_WR_REQ` goes to `S_WR_WAIT`, then to `S_BEAT_END`.
- `S_BEAT_END` returns to `S_ROW_CHK`.
- `S_ROW_END` goes back to `S_ROW_CHK` when more rows remain. Otherwise it goes to `S_BLK_END`.
- `S_BLK_END` returns to `S_CHECK`.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, `active`, `paused`, `end_flag` and `irq` are 0, no memory request is valid, and `blk_ptr` is 0.
- R2: A `start` pulse seen in idle loads `blk_ptr` from `start_ptr`, sets `active` and clears `paused`. The engine then reads the six descriptor words in order at `blk_ptr`+0, +4, +8, +12, +16 and +20. The words are: info, source, destination, length, stride, next pointer. A `start` seen while the engine is busy is ignored.
- R3: The info word bits are: bit 0 interrupt enable, bit 1 two-dimensional mode, bit 4 destination increment, bit 7 destination ignore, bit 8 source increment, bit 11 source ignore. Outside two-dimensional mode, one row of `length` bytes is moved, rounded up to whole 32-bit words. Each beat reads the source and then writes that same word to the destination.
- R4: In two-dimensional mode, each row is length[15:0] bytes and there are length[29:16]+1 rows. After every row except the last, the destination address gets stride[31:16] added and the source address gets stride[15:0] added. Both strides are signed 16-bit values. The row length is then reloaded.
- R5: After each beat, an address advances by 4 if its increment bit is set; otherwise it stays unchanged.
- R6: With source ignore set, no source read is issued and the data written is zero. With destination ignore set, no write is issued.
- R7: `len_live` shows the fetched length after setup. After each beat it shows the remaining bytes, which never go below 0. In two-dimensional mode it shows instead (remaining rows, counting the current one) << 16 OR the remaining bytes of the row.
- R8: At each block end `end_flag` is set, `irq` is also set if the interrupt enable bit is set, and `blk_ptr` takes the next-pointer word. A `flag_clr` pulse clears both flags.
- R9: The chain stops at a block boundary when `blk_ptr` is zero or `chan_en` is low. On stopping, `active` falls, `paused` rises, and `blk_ptr` keeps its value.
- R10: A request is held with unchanged address and direction until `mem_req_ready`. Every request, read or write, receives exactly one response. No new request is raised before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable, sampled at block boundaries |
| start | input | 1 | Start pulse, honoured only in idle |
| start_ptr | input | ADDR_W | First control block address |
| flag_clr | input | 1 | Clears the end and interrupt flags |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |
| active | output | 1 | Chain in progress |
| paused | output | 1 | Chain has stopped |
| end_flag | output | 1 | A block has completed |
| irq | output | 1 | Interrupt request |
| blk_ptr | output | ADDR_W | Current control block pointer |
| src_addr | output | ADDR_W | Live source address |
| dst_addr | output | ADDR_W | Live destination address |
| len_live | output | 32 | Live remaining length |

## Verification
The assertions assume that the memory side never raises `mem_rsp_valid` unless a request has been accepted and is still unanswered. They also assume that `chan_en` only matters at block boundaries. The bench's memory model therefore answers exactly one cycle after each acceptance, and only then. Its ready line stalls on a fixed cycle pattern, so the hold-until-ready rule is exercised without ever producing a spurious response. The enable is dropped only after the first enable check has already passed, so the point where the chain stops is set by the descriptor boundary.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int WORD_W     = 32;
    localparam int CB_WORDS   = 6;
    localparam int IDX_W      = $clog2(CB_WORDS);
    localparam int ROWS_W     = 15;
    localparam int BEAT_BYTES = WORD_W / 8;

    // Positions inside the info word of a control block
    localparam int BIT_IRQ_EN  = 0;
    localparam int BIT_TWO_D   = 1;
    localparam int BIT_DST_INC = 4;
    localparam int BIT_DST_IGN = 7;
    localparam int BIT_SRC_INC = 8;
    localparam int BIT_SRC_IGN = 11;

    // Descriptor word slots
    localparam int CB_INFO = 0;
    localparam int CB_SRC  = 1;
    localparam int CB_DST  = 2;
    localparam int CB_LEN  = 3;
    localparam int CB_STR  = 4;
    localparam int CB_NEXT = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH_REQ,
        S_FETCH_WAIT,
        S_SETUP,
        S_ROW_CHK,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ,
        S_WR_WAIT,
        S_BEAT_END,
        S_ROW_END,
        S_BLK_END
    } state_e;

    typedef struct packed {
        logic irq_en;
        logic two_d;
        logic src_inc;
        logic dst_inc;
        logic src_ign;
        logic dst_ign;
    } xfer_ctl_t;

endpackage

// File: rtl/cdma_cb_decode.sv
module cdma_cb_decode
    import cdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [WORD_W-1:0] info_word,
    input  logic [WORD_W-1:0] len_word,
    input  logic [WORD_W-1:0] stride_word,
    output xfer_ctl_t         ctl,
    output logic [WORD_W-1:0] row_len,
    output logic [ROWS_W-1:0] row_cnt,
    output logic [ADDR_W-1:0] src_stride,
    output logic [ADDR_W-1:0] dst_stride
);

    logic [15:0] src_raw;
    logic [15:0] dst_raw;
    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] dst_ext;

    assign ctl.irq_en  = info_word[BIT_IRQ_EN];
    assign ctl.two_d   = info_word[BIT_TWO_D];
    assign ctl.src_inc = info_word[BIT_SRC_INC];
    assign ctl.dst_inc = info_word[BIT_DST_INC];
    assign ctl.src_ign = info_word[BIT_SRC_IGN];
    assign ctl.dst_ign = info_word[BIT_DST_IGN];

    logic unused_info_bits;
    assign unused_info_bits = ^{info_word[WORD_W-1:12], info_word[10:9],
                                info_word[6:5], info_word[3:2]};

    assign src_raw = stride_word[15:0];
    assign dst_raw = stride_word[31:16];

    generate
        if (ADDR_W > 16) begin : g_wide
            assign src_ext = {{(ADDR_W-16){src_raw[15]}}, src_raw};
            assign dst_ext = {{(ADDR_W-16){dst_raw[15]}}, dst_raw};
        end else begin : g_narrow
            assign src_ext = src_raw[ADDR_W-1:0];
            assign dst_ext = dst_raw[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (ctl.two_d) begin
            row_len    = {16'b0, len_word[15:0]};
            row_cnt    = ROWS_W'(len_word[29:16]) + ROWS_W'(1);
            src_stride = src_ext;
            dst_stride = dst_ext;
        end else begin
            row_len    = len_word;
            row_cnt    = ROWS_W'(1);
            src_stride = '0;
            dst_stride = '0;
        end
    end

endmodule

// File: rtl/cdma_addr_step.sv
module cdma_addr_step
    import cdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              inc,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] beat_nxt,
    output logic [ADDR_W-1:0] row_nxt
);

    assign beat_nxt = inc ? cur + ADDR_W'(BEAT_BYTES) : cur;
    assign row_nxt  = cur + stride;

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
    import cdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              flag_clr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              active,
    output logic              paused,
    output logic              end_flag,
    output logic              irq,
    output logic [ADDR_W-1:0] blk_ptr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [WORD_W-1:0] len_live
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(CB_WORDS - 1);
    localparam logic [WORD_W-1:0] BEAT_W   = WORD_W'(BEAT_BYTES);

    state_e            state_q, state_d;
    logic [WORD_W-1:0] desc_q [CB_WORDS];
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] ptr_q, src_q, dst_q;
    logic [WORD_W-1:0] xlen_q, live_q, data_q;
    logic [ROWS_W-1:0] ylen_q;
    logic              active_q, paused_q, end_q, irq_q;

    xfer_ctl_t         ctl;
    logic [WORD_W-1:0] row_len;
    logic [ROWS_W-1:0] row_cnt;
    logic [ADDR_W-1:0] src_stride, dst_stride;
    logic [ADDR_W-1:0] src_beat, src_row, dst_beat, dst_row;
    logic [WORD_W-1:0] xlen_after, live_after;
    logic              chain_stop;

    cdma_cb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .info_word  (desc_q[CB_INFO]),
        .len_word   (desc_q[CB_LEN]),
        .stride_word(desc_q[CB_STR]),
        .ctl        (ctl),
        .row_len    (row_len),
        .row_cnt    (row_cnt),
        .src_stride (src_stride),
        .dst_stride (dst_stride)
    );

    cdma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .cur     (src_q),
        .inc     (ctl.src_inc),
        .stride  (src_stride),
        .beat_nxt(src_beat),
        .row_nxt (src_row)
    );

    cdma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .cur     (dst_q),
        .inc     (ctl.dst_inc),
        .stride  (dst_stride),
        .beat_nxt(dst_beat),
        .row_nxt (dst_row)
    );

    assign xlen_after = (xlen_q <= BEAT_W) ? '0 : xlen_q - BEAT_W;
    assign live_after = ctl.two_d ? {1'b0, ylen_q, xlen_after[15:0]} : xlen_after;
    assign chain_stop = (ptr_q == '0) || !chan_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = S_CHECK;
            S_CHECK:      state_d = chain_stop ? S_IDLE : S_FETCH_REQ;
            S_FETCH_REQ:  if (mem_req_ready) state_d = S_FETCH_WAIT;
            S_FETCH_WAIT: if (mem_rsp_valid)
                              state_d = (idx_q == LAST_IDX) ? S_SETUP : S_FETCH_REQ;
            S_SETUP:      state_d = S_ROW_CHK;
            S_ROW_CHK: begin
                if (xlen_q == '0)        state_d = S_ROW_END;
                else if (!ctl.src_ign)   state_d = S_RD_REQ;
                else if (!ctl.dst_ign)   state_d = S_WR_REQ;
                else                     state_d = S_BEAT_END;
            end
            S_RD_REQ:     if (mem_req_ready) state_d = S_RD_WAIT;
            S_RD_WAIT:    if (mem_rsp_valid)
                              state_d = ctl.dst_ign ? S_BEAT_END : S_WR_REQ;
            S_WR_REQ:     if (mem_req_ready) state_d = S_WR_WAIT;
            S_WR_WAIT:    if (mem_rsp_valid) state_d = S_BEAT_END;
            S_BEAT_END:   state_d = S_ROW_CHK;
            S_ROW_END:    state_d = (ylen_q > ROWS_W'(1)) ? S_ROW_CHK : S_BLK_END;
            S_BLK_END:    state_d = S_CHECK;
            default:      state_d = S_IDLE;
        endcase
    end

    // Memory request outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        unique case (state_q)
            S_FETCH_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ptr_q + ADDR_W'({idx_q, 2'b00});
            end
            S_RD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_q;
            end
            S_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_q;
            end
            default: ;
        endcase
    end

    assign mem_req_wdata = data_q;

    // Datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CB_WORDS; i++) desc_q[i] <= '0;
            idx_q    <= '0;
            ptr_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            xlen_q   <= '0;
            ylen_q   <= '0;
            live_q   <= '0;
            data_q   <= '0;
            active_q <= 1'b0;
            paused_q <= 1'b0;
            end_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (flag_clr) begin
                end_q <= 1'b0;
                irq_q <= 1'b0;
            end
            case (state_q)
                S_IDLE: if (start) begin
                    ptr_q    <= start_ptr;
                    active_q <= 1'b1;
                    paused_q <= 1'b0;
                end
                S_CHECK: begin
                    idx_q <= '0;
                    if (chain_stop) begin
                        active_q <= 1'b0;
                        paused_q <= 1'b1;
                    end
                end
                S_FETCH_WAIT: if (mem_rsp_valid) begin
                    desc_q[idx_q] <= mem_rsp_rdata;
                    idx_q         <= idx_q + IDX_W'(1);
                end
                S_SETUP: begin
                    src_q  <= desc_q[CB_SRC][ADDR_W-1:0];
                    dst_q  <= desc_q[CB_DST][ADDR_W-1:0];
                    xlen_q <= row_len;
                    ylen_q <= row_cnt;
                    live_q <= desc_q[CB_LEN];
                    data_q <= '0;
                end
                S_RD_WAIT: if (mem_rsp_valid) data_q <= mem_rsp_rdata;
                S_BEAT_END: begin
                    src_q  <= src_beat;
                    dst_q  <= dst_beat;
                    xlen_q <= xlen_after;
                    live_q <= live_after;
                end
                S_ROW_END: if (ylen_q > ROWS_W'(1)) begin
                    ylen_q <= ylen_q - ROWS_W'(1);
                    src_q  <= src_row;
                    dst_q  <= dst_row;
                    xlen_q <= row_len;
                end
                S_BLK_END: begin
                    end_q <= 1'b1;
                    if (ctl.irq_en) irq_q <= 1'b1;
                    ptr_q <= desc_q[CB_NEXT][ADDR_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign active   = active_q;
    assign paused   = paused_q;
    assign end_flag = end_q;
    assign irq      = irq_q;
    assign blk_ptr  = ptr_q;
    assign src_addr = src_q;
    assign dst_addr = dst_q;
    assign len_live = live_q;

    // Assertions
    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !mem_req_valid && !active_q && !irq_q); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10
    AST_RSP_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid); // R10
    AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BEAT_END) && !ctl.src_inc |=> $stable(src_q)); // R5
    AST_NO_IGNORED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write && (state_q != S_FETCH_REQ) |-> !ctl.src_ign); // R6
    AST_IRQ_HAS_END: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> end_q); // R8
    AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> paused_q && ((ptr_q == '0) || !$past(chan_en))); // R9
    AST_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_q && paused_q)); // R9

endmodule

// File: tb/chain_dma_engine_tb.sv
module chain_dma_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chan_en, start, flag_clr;
    logic [31:0] start_ptr;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        active, paused, end_flag, irq;
    logic [31:0] blk_ptr, src_addr, dst_addr, len_live;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start),
        .start_ptr(start_ptr), .flag_clr(flag_clr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .active(active), .paused(paused),
        .end_flag(end_flag), .irq(irq), .blk_ptr(blk_ptr),
        .src_addr(src_addr), .dst_addr(dst_addr), .len_live(len_live)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;

    logic [31:0] mem [0:1023];
    logic [31:0] sh  [0:1023];
    exp_t        exp_q [$];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] exp_ptr = 0, exp_src = 0, exp_dst = 0, exp_len = 0;
    logic        exp_end = 0, exp_irq = 0;

    bit          rsp_pend = 0;
    logic [31:0] pend_data = 0;
    bit          hold_v = 0;
    logic [31:0] hold_addr = 0;
    logic        hold_wr = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Memory responder and per-cycle comparison with the expected request stream
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            bit rdy;
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                check(1'b0, "R10 watchdog expired", cyc, WATCHDOG);
                finish_run();
            end
            mem_rsp_valid = rsp_pend;
            mem_rsp_rdata = rsp_pend ? pend_data : '0;
            rsp_pend = 0;
            if (hold_v) begin
                check(mem_req_valid && mem_req_addr == hold_addr && mem_req_write == hold_wr,
                      "R10 stalled request held", mem_req_addr, hold_addr);
                hold_v = 0;
            end
            rdy = ((cyc % 5) != 2);
            if (rst_n && mem_req_valid) begin
                check(!mem_rsp_valid, "R10 request overlaps response", 32'd1, 32'd0);
                if (rdy) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected request", mem_req_addr, 32'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(mem_req_write == e.wr && mem_req_addr == e.addr,
                              "R3 R4 R5 R6 request address/direction",
                              {mem_req_write, mem_req_addr[30:0]}, {e.wr, e.addr[30:0]});
                        if (e.wr)
                            check(mem_req_wdata == e.data, "R3 R6 write data",
                                  mem_req_wdata, e.data);
                    end
                    if (mem_req_write) begin
                        mem[mem_req_addr[11:2]] = mem_req_wdata;
                        pend_data = '0;
                    end else begin
                        pend_data = mem[mem_req_addr[11:2]];
                    end
                    rsp_pend = 1;
                end else begin
                    hold_v    = 1;
                    hold_addr = mem_req_addr;
                    hold_wr   = mem_req_write;
                end
            end
            mem_req_ready = rdy;
        end
    end

    task automatic put_cb(input logic [31:0] base, input logic [31:0] info,
                          input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] len, input logic [31:0] stride,
                          input logic [31:0] nxt);
        mem[base[11:2]]     = info;
        mem[base[11:2] + 1] = s;
        mem[base[11:2] + 2] = d;
        mem[base[11:2] + 3] = len;
        mem[base[11:2] + 4] = stride;
        mem[base[11:2] + 5] = nxt;
    endtask

    // Behavioural reference of the whole chain
    task automatic model_chain(input logic [31:0] p0, input int max_blk);
        logic [31:0] p, info, ln, st, xl, xrow, s, d, ss, ds, data;
        int          yl, nb;
        logic [31:0] cb [6];
        for (int i = 0; i < 1024; i++) sh[i] = mem[i];
        p  = p0;
        nb = 0;
        s  = exp_src;
        d  = exp_dst;
        while (p != 0 && nb < max_blk) begin
            for (int w = 0; w < 6; w++) begin
                exp_q.push_back('{wr: 1'b0, addr: p + 32'(4*w), data: 32'h0});
                cb[w] = sh[(p[11:2]) + 10'(w)];
            end
            info = cb[0]; s = cb[1]; d = cb[2]; ln = cb[3]; st = cb[4];
            if (info[1]) begin
                xl = {16'h0, ln[15:0]};
                yl = int'(ln[29:16]) + 1;
                ds = {{16{st[31]}}, st[31:16]};
                ss = {{16{st[15]}}, st[15:0]};
            end else begin
                xl = ln; yl = 1; ds = 0; ss = 0;
            end
            exp_len = ln;
            xrow = xl;
            while (yl != 0) begin
                while (xl != 0) begin
                    if (info[11]) data = 0;
                    else begin
                        data = sh[s[11:2]];
                        exp_q.push_back('{wr: 1'b0, addr: s, data: 32'h0});
                    end
                    if (!info[7]) begin
                        exp_q.push_back('{wr: 1'b1, addr: d, data: data});
                        sh[d[11:2]] = data;
                    end
                    if (info[8]) s = s + 4;
                    if (info[4]) d = d + 4;
                    xl = (xl <= 4) ? 0 : xl - 4;
                    exp_len = info[1] ? ((32'(yl) << 16) | xl) : xl;
                end
                yl--;
                if (yl != 0) begin
                    s  = s + ss;
                    d  = d + ds;
                    xl = xrow;
                end
            end
            exp_end = 1;
            if (info[0]) exp_irq = 1;
            p = cb[5];
            nb++;
        end
        exp_ptr = p;
        exp_src = s;
        exp_dst = d;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        exp_end = 0;
        exp_irq = 0;
        check(end_flag == 0 && irq == 0, "R8 flag clear", {end_flag, irq}, 0);
    endtask

    task automatic run(input logic [31:0] ptr, input int mid_start, input int drop_en);
        int k;
        @(negedge clk);
        start_ptr = ptr;
        start = 1;
        @(negedge clk);
        start = 0;
        k = 1;
        while ((active || k < 3) && k < 50000) begin
            @(negedge clk);
            k++;
            if (k == mid_start) begin
                start = 1;
                start_ptr = 32'h200;
            end else begin
                start = 0;
            end
            if (k == drop_en) chan_en = 0;
        end
        start = 0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected requests issued", exp_q.size(), 0);
        check(!active && paused, "R9 stop state", {active, paused}, 32'h1);
        check(blk_ptr == exp_ptr, "R8 R9 block pointer", blk_ptr, exp_ptr);
        check(src_addr == exp_src, "R5 source address", src_addr, exp_src);
        check(dst_addr == exp_dst, "R5 destination address", dst_addr, exp_dst);
        check(len_live == exp_len, "R7 live length", len_live, exp_len);
        check(end_flag == exp_end, "R8 end flag", end_flag, exp_end);
        check(irq == exp_irq, "R8 interrupt", irq, exp_irq);
    endtask

    initial begin
        rst_n = 0;
        chan_en = 1;
        start = 0;
        flag_clr = 0;
        start_ptr = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i);
        repeat (3) @(negedge clk);
        check(!active && !paused && !end_flag && !irq, "R1 reset flags",
              {active, paused, end_flag, irq}, 0);
        check(!mem_req_valid, "R1 no request in reset", mem_req_valid, 0);
        check(blk_ptr == 0, "R1 pointer in reset", blk_ptr, 0);
        rst_n = 1;
        @(negedge clk);
        check(!active && !paused && !mem_req_valid, "R1 idle after reset",
              {active, paused, mem_req_valid}, 0);

        // R3 R5 R8: single linear block, both sides incrementing, interrupt on
        put_cb(32'h200, 32'h111, 32'h400, 32'hC00, 32'd16, 32'h0, 32'h0);
        model_chain(32'h200, 100);
        run(32'h200, 0, 0);

        // R4 R7: two-dimensional block, positive strides, no interrupt
        clear_flags();
        put_cb(32'h240, 32'h112, 32'h400, 32'hD00, 32'h0001_0004, 32'h0008_0008, 32'h0);
        model_chain(32'h240, 100);
        run(32'h240, 0, 0);

        // R4 R6 R3 R2: chain of four blocks with negative stride, ignores,
        // rounding and fixed addresses; a start during the run is ignored
        clear_flags();
        put_cb(32'h100, 32'h113, 32'h400, 32'h800, 32'h0002_0008, 32'hFFF0_0004, 32'h140);
        put_cb(32'h140, 32'h810, 32'h500, 32'h900, 32'd12, 32'h0, 32'h180);
        put_cb(32'h180, 32'h180, 32'h600, 32'hA00, 32'd6, 32'h0, 32'h1C0);
        put_cb(32'h1C0, 32'h001, 32'h700, 32'h980, 32'd8, 32'h0, 32'h0);
        model_chain(32'h100, 100);
        run(32'h100, 20, 0);

        // R9: channel disabled at start, nothing fetched, pointer kept
        clear_flags();
        chan_en = 0;
        model_chain(32'h200, 0);
        run(32'h200, 0, 0);
        chan_en = 1;

        // R9: zero pointer stops at once
        model_chain(32'h0, 100);
        run(32'h0, 0, 0);

        // R9: enable dropped during the first block stops at its boundary
        clear_flags();
        put_cb(32'h280, 32'h110, 32'h400, 32'hE00, 32'd4, 32'h0, 32'h240);
        model_chain(32'h280, 1);
        run(32'h280, 0, 4);
        chan_en = 1;

        finish_run();
    end

endmodule